// File: doc/BRIEF.md
# Sensor Frame Builder with Manchester Line Coder

This block turns one sensor sample into a serial frame and drives it out as a Manchester-coded chip stream. A frame is two start bits, a payload of configurable length, and one or more check bits. The check is either a single even-parity bit or a 3-bit CRC whose starting value is programmable. The payload is taken from a user data input or from a free-running 16-bit pseudo-random generator. The coded stream feeds a downstream current modulator. Slot timing is decided outside the block, which only sees a one-cycle start strobe.

For safety testing, two injection inputs corrupt a frame on purpose. One inverts the check bits. The other sends the second start bit as 1. Configuration, payload and injection inputs are captured when a start is accepted, so a frame in flight is never altered. The line idles low between frames, and a one-cycle done pulse marks the end of every frame.

Top module: `sensor_frame_tx`

## Requirements
- R1: `cfg_len_i` selects the payload length: code 0 gives 8 bits, 1 gives 10, 2 gives 16, 3 gives 20, and 4 or any higher code gives 24. When user data is selected, the payload is the low bits of `user_data_i`.
- R2: Frame bit order is S0, S1, then the payload most significant bit first, then the check bits most significant bit first. S0 and S1 are both 0 in a normal frame.
- R3: With `cfg_crc_i`=0 the check is one bit chosen so that payload plus that bit holds an even number of ones.
- R4: With `cfg_crc_i`=1 the check is a 3-bit CRC over the payload bits only, taken most significant bit first. The polynomial is x^3+x+1, so the register shifts left and XORs 3'b011 when the outgoing top bit XOR the data bit is 1. The register starts from `cfg_seed_i`.
- R5: When `inj_crc_i` is high at an accepted start, every check bit of that frame (parity or CRC) is inverted.
- R6: When `inj_start_i` is high at an accepted start, S1 of that frame is sent as 1. S0 stays 0.
- R7: Each frame bit is sent as two chips of CHIP_DIV clock cycles each: a 0 as low then high, and a 1 as high then low. The first chip appears on `tx_o` in the cycle after the clock edge that samples `start_i` high.
- R8: With `cfg_rand_i`=1 the payload is the low bits of a 16-bit generator, zero-extended when the length exceeds 16. The generator starts at 16'hACE1 after reset and steps as {s[14:0], s[15]^s[13]^s[12]^s[10]}. It steps exactly once per accepted start, whatever the payload source, and the frame uses the value held before that step.
- R9: `tx_o` is low whenever no frame is in progress. `done_o` is high for exactly one cycle, the cycle right after the last chip.
- R10: A start while a frame is in progress is ignored. Changes to configuration, data or injection inputs during a frame have no effect on that frame, and the ignored start does not step the generator.
- R11: Synchronous reset drives `tx_o` and `done_o` low and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start-of-frame strobe |
| cfg_len_i | input | 3 | Payload length code |
| cfg_crc_i | input | 1 | 0: parity bit, 1: 3-bit CRC |
| cfg_rand_i | input | 1 | 0: user data, 1: pseudo-random payload |
| cfg_seed_i | input | 3 | CRC start value |
| user_data_i | input | 24 | User payload |
| inj_crc_i | input | 1 | Invert check bits of the next frame |
| inj_start_i | input | 1 | Corrupt the start bits of the next frame |
| tx_o | output | 1 | Manchester chip stream |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The checker watches the framing on every cycle. It checks that the line is low while idle and that the second chip of each bit is the inverse of the first. It also checks that done lasts one cycle and only follows a frame, that a frame with bits still to send stays active, and the reset state. The content of a frame can only be shown by the bench's scenarios, which compare the whole chip stream against an independently computed expectation. That content covers the payload length per code, parity and CRC values for each seed, both injections, the generator sequence, and the immunity of a frame in flight to a second start and to input changes.

// File: rtl/sft_pkg.sv
package sft_pkg;
    localparam int DATA_W = 24;
    localparam int CRC_W  = 3;
    localparam logic [CRC_W-1:0] CRC_POLY = 3'b011;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_INIT = 16'hACE1;
    localparam int FRM_W  = 2 + DATA_W + CRC_W;
    localparam int REM_W  = $clog2(FRM_W + 1);

    function automatic int len_of(input logic [2:0] code);
        case (code)
            3'd0:    return 8;
            3'd1:    return 10;
            3'd2:    return 16;
            3'd3:    return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic [CRC_W-1:0] crc_calc(input logic [DATA_W-1:0] pl,
                                                  input int len,
                                                  input logic [CRC_W-1:0] seed);
        logic [CRC_W-1:0] c;
        logic fb;
        c = seed;
        for (int j = DATA_W - 1; j >= 0; j--) begin
            if (j < len) begin
                fb = c[CRC_W-1] ^ pl[j];
                c  = {c[CRC_W-2:0], 1'b0};
                if (fb) c = c ^ CRC_POLY;
            end
        end
        return c;
    endfunction

    function automatic logic [FRM_W-1:0] frame_build(input logic [DATA_W-1:0] pl,
                                                     input int len,
                                                     input logic [CRC_W-1:0] chk,
                                                     input int chkw,
                                                     input logic s1);
        logic [FRM_W-1:0] f;
        logic b;
        f = '0;
        for (int i = 0; i < FRM_W; i++) begin
            b = 1'b0;
            if (i == 1)
                b = s1;
            else if (i >= 2 && i < 2 + len)
                b = pl[len - 1 - (i - 2)];
            else if (i >= 2 + len && i < 2 + len + chkw)
                b = chk[chkw - 1 - (i - 2 - len)];
            f[FRM_W - 1 - i] = b;
        end
        return f;
    endfunction
endpackage

// File: rtl/sft_lfsr.sv
module sft_lfsr
    import sft_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              step_i,
    output logic [LFSR_W-1:0] state_o
);
    logic [LFSR_W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) st_d = {st_q[LFSR_W-2:0], ^(st_q & LFSR_TAPS)};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= LFSR_INIT;
        else       st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/sft_encoder.sv
module sft_encoder
    import sft_pkg::*;
(
    input  logic [2:0]        cfg_len_i,
    input  logic              cfg_crc_i,
    input  logic              cfg_rand_i,
    input  logic [CRC_W-1:0]  cfg_seed_i,
    input  logic [DATA_W-1:0] user_data_i,
    input  logic [LFSR_W-1:0] rnd_i,
    input  logic              inj_crc_i,
    input  logic              inj_start_i,
    output logic [FRM_W-1:0]  frame_o,
    output logic [REM_W-1:0]  nbits_o
);
    int                plen;
    int                chkw;
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] pl;
    logic [CRC_W-1:0]  chk;

    always_comb begin
        plen = len_of(cfg_len_i);
        src  = cfg_rand_i ? DATA_W'(rnd_i) : user_data_i;
        pl   = '0;
        for (int i = 0; i < DATA_W; i++)
            if (i < plen) pl[i] = src[i];
        if (cfg_crc_i) begin
            chkw = CRC_W;
            chk  = crc_calc(pl, plen, cfg_seed_i);
        end else begin
            chkw = 1;
            chk  = {{(CRC_W-1){1'b0}}, ^pl};
        end
        if (inj_crc_i) chk = ~chk;
        frame_o = frame_build(pl, plen, chk, chkw, inj_start_i);
        nbits_o = REM_W'(2 + plen + chkw);
    end
endmodule

// File: rtl/sensor_frame_tx.sv
module sensor_frame_tx
    import sft_pkg::*;
#(
    parameter int CHIP_DIV = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [2:0]        cfg_len_i,
    input  logic              cfg_crc_i,
    input  logic              cfg_rand_i,
    input  logic [2:0]        cfg_seed_i,
    input  logic [23:0]       user_data_i,
    input  logic              inj_crc_i,
    input  logic              inj_start_i,
    output logic              tx_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(CHIP_DIV + 1);

    typedef struct packed {
        logic             busy;
        logic             half;
        logic [CNT_W-1:0] cnt;
        logic [REM_W-1:0] rem;
        logic [FRM_W-1:0] sh;
        logic             tx;
        logic             done;
    } st_t;

    st_t st_d, st_q;

    logic              accept;
    logic [LFSR_W-1:0] rnd;
    logic [FRM_W-1:0]  frame;
    logic [REM_W-1:0]  nbits;

    assign accept = start_i && !st_q.busy;

    sft_lfsr u_lfsr (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .step_i  (accept),
        .state_o (rnd)
    );

    sft_encoder u_enc (
        .cfg_len_i   (cfg_len_i),
        .cfg_crc_i   (cfg_crc_i),
        .cfg_rand_i  (cfg_rand_i),
        .cfg_seed_i  (cfg_seed_i),
        .user_data_i (user_data_i),
        .rnd_i       (rnd),
        .inj_crc_i   (inj_crc_i),
        .inj_start_i (inj_start_i),
        .frame_o     (frame),
        .nbits_o     (nbits)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.half = 1'b0;
                st_d.cnt  = '0;
                st_d.rem  = nbits;
                st_d.sh   = frame;
            end
        end else if (st_q.cnt == CNT_W'(CHIP_DIV - 1)) begin
            st_d.cnt = '0;
            if (st_q.half) begin
                st_d.half = 1'b0;
                if (st_q.rem == REM_W'(1)) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.rem = st_q.rem - REM_W'(1);
                    st_d.sh  = {st_q.sh[FRM_W-2:0], 1'b0};
                end
            end else begin
                st_d.half = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        st_d.tx = st_d.busy & (st_d.sh[FRM_W-1] ^ st_d.half);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign tx_o   = st_q.tx;
    assign done_o = st_q.done;
endmodule

// File: rtl/sft_checker.sv
module sft_checker
    import sft_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             tx_i,
    input logic             done_i,
    input logic             busy_i,
    input logic             half_i,
    input logic [REM_W-1:0] rem_i
);
    p_idle_low_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_i |-> !tx_i);

    p_done_single_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        done_i |=> !done_i);

    p_done_idle_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        done_i |-> !busy_i);

    p_chip_pair_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_i && $rose(half_i)) |-> (tx_i == !$past(tx_i)));

    p_frame_holds_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_i && rem_i > REM_W'(1)) |=> busy_i);

    p_reset_state_r11: assert property (@(posedge clk_i)
        rst_i |=> (!tx_i && !done_i && !busy_i));
endmodule

bind sensor_frame_tx sft_checker u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tx_i   (tx_o),
    .done_i (done_o),
    .busy_i (st_q.busy),
    .half_i (st_q.half),
    .rem_i  (st_q.rem)
);

// File: tb/sensor_frame_tx_test.sv
`timescale 1ns/1ps
module sensor_frame_tx_test;
    localparam int D = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  len_c = '0;
    logic        crc_m = 1'b0;
    logic        rnd_m = 1'b0;
    logic [2:0]  seed = '0;
    logic [23:0] data = '0;
    logic        fcrc = 1'b0;
    logic        fsb = 1'b0;
    logic        tx;
    logic        done;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;
    logic [15:0] exp_lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    sensor_frame_tx #(.CHIP_DIV(D)) uut (
        .clk_i(clk), .rst_i(rst), .start_i(start), .cfg_len_i(len_c),
        .cfg_crc_i(crc_m), .cfg_rand_i(rnd_m), .cfg_seed_i(seed),
        .user_data_i(data), .inj_crc_i(fcrc), .inj_start_i(fsb),
        .tx_o(tx), .done_o(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int blen(input logic [2:0] c);
        if (c == 3'd0) return 8;
        if (c == 3'd1) return 10;
        if (c == 3'd2) return 16;
        if (c == 3'd3) return 20;
        return 24;
    endfunction

    // one frame: expected bits from the requirements, chips compared, done and idle checked
    task automatic run_frame(input logic [2:0] lc, input logic cm, input logic rm,
                             input logic [2:0] sd, input logic [23:0] dv,
                             input logic fc, input logic fs, input int poke);
        logic [23:0] pl;
        logic [2:0]  c;
        logic        fb;
        logic        bits[$];
        int          L;
        int          bad;
        int          n;
        logic        got;
        logic        want;
        L = blen(lc);
        pl = rm ? {8'h00, exp_lfsr} : dv;
        for (int i = L; i < 24; i++) pl[i] = 1'b0;
        bits.push_back(1'b0);
        bits.push_back(fs);
        for (int i = L - 1; i >= 0; i--) bits.push_back(pl[i]);
        if (cm) begin
            c = sd;
            for (int i = L - 1; i >= 0; i--) begin
                fb = c[2] ^ pl[i];
                c = {c[1:0], 1'b0} ^ (fb ? 3'b011 : 3'b000);
            end
            if (fc) c = ~c;
            for (int i = 2; i >= 0; i--) bits.push_back(c[i]);
        end else begin
            bits.push_back((^pl) ^ fc);
        end
        exp_lfsr = {exp_lfsr[14:0], exp_lfsr[15] ^ exp_lfsr[13] ^ exp_lfsr[12] ^ exp_lfsr[10]};
        n = bits.size();

        @(negedge clk);
        len_c = lc; crc_m = cm; rnd_m = rm; seed = sd; data = dv; fcrc = fc; fsb = fs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bad = -1;
        got = 1'b0;
        want = 1'b0;
        for (int k = 0; k < 2 * n; k++) begin
            logic e;
            e = bits[k / 2] ^ logic'(k % 2);
            if (tx !== e && bad < 0) begin
                bad = k; got = tx; want = e;
            end
            if (k == poke) begin
                // R10: second start and changed inputs mid-frame must not matter
                start = 1'b1;
                len_c = ~lc; crc_m = ~cm; rnd_m = ~rm; seed = ~sd;
                data = ~dv; fcrc = ~fc; fsb = ~fs;
            end
            for (int r = 0; r < D; r++) begin
                @(negedge clk);
                start = 1'b0;
            end
        end
        if (bad >= 0)
            $display("FAIL R1/R2/R3/R4/R5/R6/R7/R8 chip %0d of len code %0d crc %0d rnd %0d: actual=%0b expected=%0b",
                     bad, lc, cm, rm, got, want);
        checks++;
        if (bad >= 0) errors++;
        check("R9 done pulse after last chip", {31'b0, done}, 32'd1);
        check("R9 idle low at done", {31'b0, tx}, 32'd0);
        @(negedge clk);
        check("R9 done lasts one cycle", {31'b0, done}, 32'd0);
        check("R9 idle low after frame", {31'b0, tx}, 32'd0);
        len_c = lc; crc_m = cm; rnd_m = rm; seed = sd; data = dv; fcrc = fc; fsb = fs;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset tx low", {31'b0, tx}, 32'd0);
        check("R11 reset done low", {31'b0, done}, 32'd0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 idle low without start", {31'b0, tx}, 32'd0);
        check("R9 no done without start", {31'b0, done}, 32'd0);

        // R1 R2 R3 R4 R5 R6: sweep lengths, protection, seeds and both injections
        for (int l = 0; l < 5; l++)
            for (int m = 0; m < 2; m++)
                for (int f = 0; f < 4; f++) begin
                    logic [23:0] dv;
                    dv = 24'h5A3C96 ^ (24'h13579B * 24'(l * 8 + m * 4 + f));
                    run_frame(3'(l), 1'(m), 1'b0, 3'(l + f + m), dv, f[0], f[1], -1);
                end
        // R1: codes above 4 behave as 24 bits
        for (int l = 5; l < 8; l++)
            run_frame(3'(l), 1'(l % 2), 1'b0, 3'(l), 24'hC0FFEE ^ 24'(l), 1'b0, 1'b0, -1);
        // R8: random payload sequence across lengths, both protections
        for (int k = 0; k < 10; k++)
            run_frame(3'(k % 5), 1'(k % 2), 1'b1, 3'(k), 24'hFFFFFF, 1'b0, 1'b0, -1);
        // R10: start and input changes during a frame, user and random sources
        run_frame(3'd1, 1'b1, 1'b0, 3'd5, 24'h0002A1, 1'b0, 1'b0, 7);
        run_frame(3'd2, 1'b0, 1'b1, 3'd2, 24'h000000, 1'b0, 1'b0, 12);
        run_frame(3'd0, 1'b1, 1'b1, 3'd7, 24'h000000, 1'b1, 1'b0, 3);
        // R11: reset in the middle of a frame
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R11 tx low after reset mid-frame", {31'b0, tx}, 32'd0);
        check("R11 done low after reset mid-frame", {31'b0, done}, 32'd0);
        rst = 1'b0;
        exp_lfsr = 16'hACE1;
        run_frame(3'd0, 1'b0, 1'b1, 3'd0, 24'h0, 1'b0, 1'b0, -1);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule